// File: doc/BRIEF.md
# Cached FFT Address Generator

This block sequences the memory traffic of a radix-2 decimation-in-frequency FFT or inverse FFT whose length can be chosen at run time between 64 and 2048 points. Rather than sweeping main memory once per butterfly stage, the transform is cut into super-stages. In each super-stage, one group of words at a time is copied into a small local cache. Several consecutive butterfly stages run on that group inside the cache, and the group is then written back. The generator emits the main-memory address with read or write strobes, the matching cache slot, the two cache slots of every butterfly, and the twiddle-ROM index. A flag marks inverse transforms, so the arithmetic unit conjugates the twiddle.

The caller picks a size code and a direction and pulses `start`. The block runs the whole transform on its own, pausing on each butterfly until the arithmetic unit acknowledges it with `bfly_done`. When the last group has been written back, it pulses `done`. All sizes share one group counter that is scaled to the largest size, so a smaller transform walks the large sequence with its low-order digits dropped. The twiddle index is always expressed for a ROM sized for 2048 points.

Top module: `cfft_addr_gen`

## Requirements
- R1: Size code c selects log2 length L = 6 + c for c = 0..5 (64..2048 points); codes 6 and 7 behave as code 5. A run has ceil(L/2) super-stages, each processing 2^(L-2) groups of four words, with group numbers in ascending order.
- R2: `phase` is 0 idle, 1 load, 2 compute, 3 write-back. Every group goes load, then compute, then write-back. `mem_rd` is high only in load, `mem_wr` only in write-back, and never both at once.
- R3: Load and write-back each last four cycles, with `cache_addr` stepping 0,1,2,3. The main address places the 2-bit cache slot at bit positions lo+1..lo, where lo = max(L - 2(p+1), 0) for super-stage p.
- R4: The group number g fills the remaining address bits: its low lo bits go below the slot field, and its other bits go directly above it.
- R5: Super-stage p runs min(2, L-2p) stages. Global stage s = 2p + j pairs words differing in memory bit m = L-1-s, which is cache bit m-lo. For butterflies 0 and 1 of each stage, `bfly_addr_a` is the butterfly number with a 0 inserted at that cache bit, and `bfly_addr_b` is `bfly_addr_a` with that bit set.
- R6: `bfly_req` and the butterfly addresses hold until `bfly_done` is sampled high. `bfly_done` has no effect outside compute.
- R7: `tw_index` equals ((A mod 2^m) << s) << (11-L), where A is the main address of the word in slot `bfly_addr_a`.
- R8: `tw_conj` equals the `inverse` input sampled with the accepted `start`, and it stays constant for the whole run.
- R9: `done` is high for exactly one cycle, the cycle after the final write-back slot, with `phase` back at idle and `busy` low.
- R10: `start`, `size_sel` and `inverse` are ignored while `busy` is high.
- R11: After synchronous reset, the block is idle with `done`, `busy`, `mem_rd`, `mem_wr` and `bfly_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transform when idle |
| size_sel | input | 3 | Transform length code |
| inverse | input | 1 | 1 selects inverse transform |
| bfly_done | input | 1 | Arithmetic unit accepted the current butterfly |
| phase | output | 2 | Current phase code |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Main-memory read strobe |
| mem_wr | output | 1 | Main-memory write strobe |
| mem_addr | output | 11 | Main-memory word address |
| cache_addr | output | 2 | Cache slot for the current load or write-back |
| bfly_req | output | 1 | A butterfly is presented |
| bfly_addr_a | output | 2 | Cache slot of the upper butterfly input |
| bfly_addr_b | output | 2 | Cache slot of the lower butterfly input |
| tw_index | output | 10 | Twiddle ROM index scaled to 2048 points |
| tw_conj | output | 1 | Conjugate the twiddle (inverse transform) |

## Verification
Odd lengths are the main target. For 128 and 2048 points, the last super-stage has a single stage and its slot field must clamp to bit 0. A design that shifted the window past the bottom would repeat or skip addresses, or run a phantom second stage. The bench compares every address of full 64-, 128-, 256- and 2048-point runs against a model built from the formulas, so a group counter that is not truncated correctly shows up at once as wrong low address bits for the shorter sizes. Butterflies are acknowledged late, and stray acknowledgements arrive during load and write-back, to catch a handshake that advances early or leaks into the other phases. A start pulse with a new size and direction in mid-run, and the unused size code 7, catch a design that re-latches its configuration or decodes out of range.

// File: rtl/cfft_ag_pkg.sv
// Shared types for the cached FFT address generator.
package cfft_ag_pkg;

    // Phase of the current group; the encoding is visible on the phase port.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_COMP = 2'd2,
        PH_WB   = 2'd3
    } phase_e;

endpackage

// File: rtl/cfft_ag_deposit.sv
// Main-memory address builder.
// Places a CW-bit cache slot at bit position lo of the address. Group bits
// below lo stay in place and the rest of the group moves up above the slot.
// Assumes grp_i only has bits set below L-CW for the running length L.
module cfft_ag_deposit #(
    parameter int AW = 11,
    parameter int GW = 9,
    parameter int CW = 2,
    parameter int SW = 4
) (
    input  logic [GW-1:0] grp_i,
    input  logic [CW-1:0] idx_i,
    input  logic [SW-1:0] lo_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] grp_x;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] part_low;
    logic [AW-1:0] part_mid;
    logic [AW-1:0] part_high;

    // Split the group around the slot field and merge the three parts.
    always_comb begin
        grp_x     = AW'(grp_i);
        low_mask  = (AW'(1) << lo_i) - AW'(1);
        part_low  = grp_x & low_mask;
        part_high = (grp_x & ~low_mask) << CW;
        part_mid  = AW'(idx_i) << lo_i;
        addr_o    = part_high | part_mid | part_low;
    end

endmodule

// File: rtl/cfft_ag_bfly_pair.sv
// Butterfly slot pair generator.
// Turns a butterfly number inside the cache into the two slots it combines.
// The slots differ only in cache bit cbit. Assumes cbit_i < CW.
module cfft_ag_bfly_pair #(
    parameter int CW  = 2,
    parameter int BW  = 1,
    parameter int CBW = 1
) (
    input  logic [BW-1:0]  bcnt_i,
    input  logic [CBW-1:0] cbit_i,
    output logic [CW-1:0]  slot_a_o,
    output logic [CW-1:0]  slot_b_o
);

    logic [CW-1:0] cnt_x;
    logic [CW-1:0] below;

    // Insert a zero at cbit for the upper slot, then set it for the lower.
    always_comb begin
        cnt_x    = CW'(bcnt_i);
        below    = (CW'(1) << cbit_i) - CW'(1);
        slot_a_o = ((cnt_x & ~below) << 1) | (cnt_x & below);
        slot_b_o = slot_a_o | (CW'(1) << cbit_i);
    end

endmodule

// File: rtl/cfft_ag_twiddle.sv
// Twiddle index generator.
// For a decimation-in-frequency stage s on memory bit m, the exponent is
// (addr mod 2^m) * 2^s in the running length. It is scaled to a ROM sized for
// 2^MAX_LOG2 points by shifting up by MAX_LOG2 - L.
module cfft_ag_twiddle #(
    parameter int AW       = 11,
    parameter int SW       = 4,
    parameter int TWW      = 10,
    parameter int MAX_LOG2 = 11
) (
    input  logic [AW-1:0]  addr_i,
    input  logic [SW-1:0]  mbit_i,
    input  logic [SW-1:0]  gstage_i,
    input  logic [SW-1:0]  log2_i,
    output logic [TWW-1:0] tw_o
);

    logic [AW-1:0] in_mask;
    logic [AW-1:0] expo;
    logic [AW-1:0] scaled;
    logic [SW-1:0] scale_sh;

    // Mask to the in-block offset, weight by stage, scale to the largest size.
    always_comb begin
        in_mask  = (AW'(1) << mbit_i) - AW'(1);
        expo     = (addr_i & in_mask) << gstage_i;
        scale_sh = SW'(MAX_LOG2) - log2_i;
        scaled   = expo << scale_sh;
        tw_o     = TWW'(scaled);
    end

endmodule

// File: rtl/cfft_ag_ctrl.sv
// Sequencer of the cached FFT address generator.
// Holds the run configuration and walks super-stage, group, slot, stage and
// butterfly counters. Derives the slot window and the stage bit positions.
// The group counter is scaled to the largest size. It steps by
// 2^(MAX_LOG2-L), so the group of a shorter run is the full-size count with
// its low digits dropped. Assumes CACHE_LOG2 >= 2 and MIN_LOG2 >= 2*CACHE_LOG2.
module cfft_ag_ctrl
    import cfft_ag_pkg::*;
#(
    parameter int MAX_LOG2   = 11,
    parameter int MIN_LOG2   = 6,
    parameter int CACHE_LOG2 = 2,
    parameter int SEL_W      = 3,
    parameter int SW         = 4,
    parameter int GW         = 9,
    parameter int CBW        = 1,
    parameter int BW         = 1,
    parameter int PW         = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [SEL_W-1:0]      size_sel_i,
    input  logic                  inverse_i,
    input  logic                  bfly_done_i,
    output phase_e                phase_o,
    output logic [SW-1:0]         log2_o,
    output logic                  inv_o,
    output logic [GW-1:0]         group_o,
    output logic [CACHE_LOG2-1:0] ecnt_o,
    output logic [BW-1:0]         bcnt_o,
    output logic [SW-1:0]         lo_o,
    output logic [SW-1:0]         gstage_o,
    output logic [SW-1:0]         mbit_o,
    output logic [CBW-1:0]        cbit_o,
    output logic                  done_o
);

    phase_e                phase_q;
    logic [SW-1:0]         log2_q;
    logic                  inv_q;
    logic [PW-1:0]         pass_q;
    logic [GW-1:0]         gcnt_q;
    logic [CACHE_LOG2-1:0] ecnt_q;
    logic [CBW-1:0]        stg_q;
    logic [BW-1:0]         bcnt_q;
    logic                  done_q;

    logic [SW-1:0]         req_log2;
    logic [SW-1:0]         trunc_sh;
    logic [GW-1:0]         gstep;
    logic [GW:0]           gsum;
    logic                  last_grp;
    logic                  last_pass;
    logic                  last_stg;
    logic [SW-1:0]         lo_w;
    logic [SW-1:0]         gs_w;
    logic [SW-1:0]         mb_w;
    logic [CBW-1:0]        cb_w;

    // Decode the size code, clamping codes past the largest size.
    always_comb begin
        int want;
        want = MIN_LOG2 + int'(size_sel_i);
        if (want > MAX_LOG2) want = MAX_LOG2;
        req_log2 = SW'(want);
    end

    // Group counter stepping and truncation to the running length.
    always_comb begin
        trunc_sh = SW'(MAX_LOG2) - log2_q;
        gstep    = GW'(1) << trunc_sh;
        gsum     = {1'b0, gcnt_q} + {1'b0, gstep};
        last_grp = gsum[GW];
    end

    // Slot window, stage count and bit positions of the current super-stage.
    always_comb begin
        int lg, ps, st, lo, nst, gs, mb;
        lg  = int'(log2_q);
        ps  = int'(pass_q);
        st  = int'(stg_q);
        lo  = lg - (ps + 1) * CACHE_LOG2;
        if (lo < 0) lo = 0;
        nst = lg - ps * CACHE_LOG2;
        if (nst > CACHE_LOG2) nst = CACHE_LOG2;
        gs  = ps * CACHE_LOG2 + st;
        mb  = lg - 1 - gs;
        last_pass = ((ps + 1) * CACHE_LOG2) >= lg;
        last_stg  = (st == nst - 1);
        lo_w = SW'(lo);
        gs_w = SW'(gs);
        mb_w = SW'(mb);
        cb_w = CBW'(mb - lo);
    end

    // Phase machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            log2_q  <= SW'(MAX_LOG2);
            inv_q   <= 1'b0;
            pass_q  <= '0;
            gcnt_q  <= '0;
            ecnt_q  <= '0;
            stg_q   <= '0;
            bcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        log2_q  <= req_log2;
                        inv_q   <= inverse_i;
                        pass_q  <= '0;
                        gcnt_q  <= '0;
                        ecnt_q  <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    ecnt_q <= ecnt_q + 1'b1;
                    if (&ecnt_q) begin
                        stg_q   <= '0;
                        bcnt_q  <= '0;
                        phase_q <= PH_COMP;
                    end
                end
                PH_COMP: begin
                    if (bfly_done_i) begin
                        bcnt_q <= bcnt_q + 1'b1;
                        if (&bcnt_q) begin
                            if (last_stg) begin
                                stg_q   <= '0;
                                phase_q <= PH_WB;
                            end else begin
                                stg_q <= stg_q + 1'b1;
                            end
                        end
                    end
                end
                PH_WB: begin
                    ecnt_q <= ecnt_q + 1'b1;
                    if (&ecnt_q) begin
                        if (last_grp) begin
                            gcnt_q <= '0;
                            if (last_pass) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                pass_q  <= pass_q + 1'b1;
                                phase_q <= PH_LOAD;
                            end
                        end else begin
                            gcnt_q  <= gsum[GW-1:0];
                            phase_q <= PH_LOAD;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Present state and derived positions to the address datapath.
    always_comb begin
        phase_o  = phase_q;
        log2_o   = log2_q;
        inv_o    = inv_q;
        group_o  = gcnt_q >> trunc_sh;
        ecnt_o   = ecnt_q;
        bcnt_o   = bcnt_q;
        lo_o     = lo_w;
        gstage_o = gs_w;
        mbit_o   = mb_w;
        cbit_o   = cb_w;
        done_o   = done_q;
    end

endmodule

// File: rtl/cfft_addr_gen.sv
// Cached FFT/IFFT address generator, top level.
// Produces main-memory, cache and twiddle addresses for a run-time sized
// radix-2 transform that works one cache-sized group at a time. Combines the
// sequencer with the address datapath and gates each output to its phase.
// Assumes main memory, cache and ROM latencies are aligned outside this block.
module cfft_addr_gen
    import cfft_ag_pkg::*;
#(
    parameter int MAX_LOG2   = 11,
    parameter int MIN_LOG2   = 6,
    parameter int CACHE_LOG2 = 2,
    parameter int SEL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SEL_W-1:0]      size_sel,
    input  logic                  inverse,
    input  logic                  bfly_done,
    output logic [1:0]            phase,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [MAX_LOG2-1:0]   mem_addr,
    output logic [CACHE_LOG2-1:0] cache_addr,
    output logic                  bfly_req,
    output logic [CACHE_LOG2-1:0] bfly_addr_a,
    output logic [CACHE_LOG2-1:0] bfly_addr_b,
    output logic [MAX_LOG2-2:0]   tw_index,
    output logic                  tw_conj
);

    localparam int AW   = MAX_LOG2;
    localparam int TWW  = MAX_LOG2 - 1;
    localparam int GW   = MAX_LOG2 - CACHE_LOG2;
    localparam int SW   = $clog2(MAX_LOG2 + 1);
    localparam int CBW  = (CACHE_LOG2 > 1) ? $clog2(CACHE_LOG2) : 1;
    localparam int BW   = CACHE_LOG2 - 1;
    localparam int MAXP = (MAX_LOG2 + CACHE_LOG2 - 1) / CACHE_LOG2;
    localparam int PW   = $clog2(MAXP + 1);
    localparam int NDEP = 2;

    phase_e                ph;
    logic [SW-1:0]         log2_w;
    logic                  inv_w;
    logic [GW-1:0]         group_w;
    logic [CACHE_LOG2-1:0] ecnt_w;
    logic [BW-1:0]         bcnt_w;
    logic [SW-1:0]         lo_w;
    logic [SW-1:0]         gstage_w;
    logic [SW-1:0]         mbit_w;
    logic [CBW-1:0]        cbit_w;
    logic                  done_w;
    logic [CACHE_LOG2-1:0] slot_a;
    logic [CACHE_LOG2-1:0] slot_b;
    logic [TWW-1:0]        tw_w;
    logic [CACHE_LOG2-1:0] dep_idx  [NDEP];
    logic [AW-1:0]         dep_addr [NDEP];

    cfft_ag_ctrl #(
        .MAX_LOG2   (MAX_LOG2),
        .MIN_LOG2   (MIN_LOG2),
        .CACHE_LOG2 (CACHE_LOG2),
        .SEL_W      (SEL_W),
        .SW         (SW),
        .GW         (GW),
        .CBW        (CBW),
        .BW         (BW),
        .PW         (PW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .size_sel_i  (size_sel),
        .inverse_i   (inverse),
        .bfly_done_i (bfly_done),
        .phase_o     (ph),
        .log2_o      (log2_w),
        .inv_o       (inv_w),
        .group_o     (group_w),
        .ecnt_o      (ecnt_w),
        .bcnt_o      (bcnt_w),
        .lo_o        (lo_w),
        .gstage_o    (gstage_w),
        .mbit_o      (mbit_w),
        .cbit_o      (cbit_w),
        .done_o      (done_w)
    );

    cfft_ag_bfly_pair #(
        .CW  (CACHE_LOG2),
        .BW  (BW),
        .CBW (CBW)
    ) u_pair (
        .bcnt_i   (bcnt_w),
        .cbit_i   (cbit_w),
        .slot_a_o (slot_a),
        .slot_b_o (slot_b)
    );

    // Slot feeding each address builder: 0 = transfer slot, 1 = butterfly top.
    always_comb begin
        dep_idx[0] = ecnt_w;
        dep_idx[1] = slot_a;
    end

    // One address builder for memory transfers, one for the twiddle operand.
    for (genvar k = 0; k < NDEP; k++) begin : g_dep
        cfft_ag_deposit #(
            .AW (AW),
            .GW (GW),
            .CW (CACHE_LOG2),
            .SW (SW)
        ) u_dep (
            .grp_i  (group_w),
            .idx_i  (dep_idx[k]),
            .lo_i   (lo_w),
            .addr_o (dep_addr[k])
        );
    end

    cfft_ag_twiddle #(
        .AW       (AW),
        .SW       (SW),
        .TWW      (TWW),
        .MAX_LOG2 (MAX_LOG2)
    ) u_tw (
        .addr_i   (dep_addr[1]),
        .mbit_i   (mbit_w),
        .gstage_i (gstage_w),
        .log2_i   (log2_w),
        .tw_o     (tw_w)
    );

    // Gate each output group to the phase it belongs to.
    always_comb begin
        logic xfer, comp;
        xfer        = (ph == PH_LOAD) || (ph == PH_WB);
        comp        = (ph == PH_COMP);
        phase       = ph;
        busy        = (ph != PH_IDLE);
        done        = done_w;
        mem_rd      = (ph == PH_LOAD);
        mem_wr      = (ph == PH_WB);
        mem_addr    = xfer ? dep_addr[0] : '0;
        cache_addr  = xfer ? ecnt_w : '0;
        bfly_req    = comp;
        bfly_addr_a = comp ? slot_a : '0;
        bfly_addr_b = comp ? slot_b : '0;
        tw_index    = comp ? tw_w : '0;
        tw_conj     = inv_w;
    end

endmodule

// File: rtl/cfft_ag_checker.sv
// Protocol checker for the cached FFT address generator, bound to the top.
// Watches the ports only.
module cfft_ag_checker #(
    parameter int AW = 11,
    parameter int CW = 2,
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bfly_done,
    input logic [1:0]    phase,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          bfly_req,
    input logic [CW-1:0] bfly_addr_a,
    input logic [CW-1:0] bfly_addr_b,
    input logic [TW-1:0] tw_index,
    input logic          tw_conj
);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == 2'd3) && !busy);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bfly_req && !bfly_done) |=> bfly_req && $stable(bfly_addr_a)
            && $stable(bfly_addr_b) && $stable(tw_index));

    assert_pair_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bfly_req |-> ($countones(bfly_addr_a ^ bfly_addr_b) == 1)
            && ((bfly_addr_a & ~bfly_addr_b) == '0));

    assert_conj_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tw_conj));

    assert_compute_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1);

    assert_wb_after_compute_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && $past(phase) != 2'd3) |-> $past(phase) == 2'd2);

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd && !mem_wr && !bfly_req);

endmodule

bind cfft_addr_gen cfft_ag_checker #(
    .AW (MAX_LOG2),
    .CW (CACHE_LOG2),
    .TW (MAX_LOG2 - 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bfly_done   (bfly_done),
    .phase       (phase),
    .busy        (busy),
    .done        (done),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .bfly_req    (bfly_req),
    .bfly_addr_a (bfly_addr_a),
    .bfly_addr_b (bfly_addr_b),
    .tw_index    (tw_index),
    .tw_conj     (tw_conj)
);

// File: tb/cfft_addr_gen_tb_top.sv
// Directed bench for the cached FFT address generator: each task runs one
// scenario and compares every output cycle against a formula model.
module cfft_addr_gen_tb_top;

    localparam int MAXL = 11;
    localparam int CWB  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  size_sel = 3'd0;
    logic        inverse = 1'b0;
    logic        bfly_done = 1'b0;
    logic [1:0]  phase;
    logic        busy, done, mem_rd, mem_wr, bfly_req, tw_conj;
    logic [10:0] mem_addr;
    logic [1:0]  cache_addr, bfly_addr_a, bfly_addr_b;
    logic [9:0]  tw_index;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cfft_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .inverse(inverse), .bfly_done(bfly_done), .phase(phase), .busy(busy),
        .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .cache_addr(cache_addr), .bfly_req(bfly_req), .bfly_addr_a(bfly_addr_a),
        .bfly_addr_b(bfly_addr_b), .tw_index(tw_index), .tw_conj(tw_conj)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected main address: bit-by-bit placement of slot and group digits.
    function automatic int exp_addr(input int g, input int slot, input int lo);
        int a = 0;
        for (int i = 0; i < MAXL; i++) begin
            int bitv;
            if (i < lo)            bitv = (g >> i) & 1;
            else if (i < lo + CWB) bitv = (slot >> (i - lo)) & 1;
            else                   bitv = (g >> (i - CWB)) & 1;
            a = a | (bitv << i);
        end
        return a;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b1; bfly_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "phase after reset", int'(phase), 0);
        check("R11", "busy after reset", int'(busy), 0);
        check("R11", "done after reset", int'(done), 0);
        check("R11", "strobes after reset", int'({mem_rd, mem_wr, bfly_req}), 0);
        rst_n = 1'b1; start = 1'b0;
        // R6: acknowledgements in idle must do nothing
        bfly_done = 1'b1;
        repeat (3) @(negedge clk);
        check("R6", "idle phase with stray done", int'(phase), 0);
        check("R6", "idle request with stray done", int'(bfly_req), 0);
        bfly_done = 1'b0;
    endtask

    // Full transform in lockstep with the model.
    task automatic run_xfer(input int code, input bit inv, input int dly,
                            input bit stray, input bit poke, input string tag);
        int lg, npass, ngrp;
        bit poked = 1'b0;
        @(negedge clk);
        size_sel = 3'(code); inverse = inv; start = 1'b1; bfly_done = 1'b0;
        lg = 6 + code;
        if (lg > MAXL) lg = MAXL;
        npass = (lg + 1) / 2;
        ngrp  = 1 << (lg - 2);
        for (int p = 0; p < npass; p++) begin
            int lo  = (lg - 2 * (p + 1) > 0) ? lg - 2 * (p + 1) : 0;
            int nst = (lg - 2 * p > 2) ? 2 : lg - 2 * p;
            for (int g = 0; g < ngrp; g++) begin
                for (int e = 0; e < 4; e++) begin
                    @(negedge clk);
                    start = 1'b0; bfly_done = stray;
                    if (poke) begin size_sel = 3'(code ^ 5); inverse = ~inv; end
                    check("R2", "load phase", int'(phase), 1);
                    check("R2", "load strobes", int'({mem_rd, mem_wr}), 2);
                    check("R3", "load slot", int'(cache_addr), e);
                    check("R3 R4", "load address", int'(mem_addr), exp_addr(g, e, lo));
                end
                for (int j = 0; j < nst; j++) begin
                    int s  = 2 * p + j;
                    int mb = lg - 1 - s;
                    int cb = mb - lo;
                    for (int bi = 0; bi < 2; bi++) begin
                        int ea = ((bi >> cb) << (cb + 1)) | (bi & ((1 << cb) - 1));
                        int eb = ea | (1 << cb);
                        int ta = exp_addr(g, ea, lo);
                        int et = ((ta & ((1 << mb) - 1)) << s) << (MAXL - lg);
                        for (int w = 0; w <= dly; w++) begin
                            @(negedge clk);
                            bfly_done = (w == dly);
                            start = 1'b0;
                            if (poke && !poked) begin start = 1'b1; poked = 1'b1; end
                            check("R2", "compute phase", int'(phase), 2);
                            check("R6", "request held", int'(bfly_req), 1);
                            check("R5", "slot a", int'(bfly_addr_a), ea);
                            check("R5", "slot b", int'(bfly_addr_b), eb);
                            check("R7", "twiddle index", int'(tw_index), et);
                            check("R8", "conjugate flag", int'(tw_conj), int'(inv));
                        end
                    end
                end
                for (int e = 0; e < 4; e++) begin
                    @(negedge clk);
                    start = 1'b0; bfly_done = stray;
                    check("R2", "write-back phase", int'(phase), 3);
                    check("R2", "write-back strobes", int'({mem_rd, mem_wr}), 1);
                    check("R3", "write-back slot", int'(cache_addr), e);
                    check("R3 R4", "write-back address", int'(mem_addr), exp_addr(g, e, lo));
                end
            end
        end
        @(negedge clk);
        bfly_done = 1'b0; start = 1'b0;
        check("R9", {tag, " done pulse"}, int'(done), 1);
        check("R9", {tag, " idle at done"}, int'({busy, phase}), 0);
        @(negedge clk);
        check("R9", {tag, " done single"}, int'(done), 0);
        check(poke ? "R10" : "R1", {tag, " stays idle"}, int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        run_xfer(0, 1'b0, 0, 1'b0, 1'b0, "R1 64-point forward");
        run_xfer(1, 1'b1, 2, 1'b1, 1'b0, "R1 128-point inverse, slow R6");
        run_xfer(2, 1'b0, 1, 1'b0, 1'b1, "R10 256-point with start poke");
        run_xfer(5, 1'b1, 0, 1'b0, 1'b0, "R1 2048-point");
        run_xfer(7, 1'b0, 0, 1'b1, 1'b0, "R1 code 7 clamp");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule